// File: doc/BRIEF.md
# History-Based Branch Predictor

This block predicts conditional branches for a dual-lane in-order pipeline. A direct-mapped branch target buffer of 256 entries, indexed by the low fetch-address bits and tagged with the remaining bits, remembers each branch's target and its recent outcomes. In the lookup cycle the front end presents the fetch address, the branch's static direction (target below or above the branch) and the decoded target. The block answers with a hit flag, a taken/not-taken guess and the target to steer to, all combinationally from registered state.

When a branch resolves, the update port writes its outcome and target. A branch that is not in the buffer gets an entry. A branch that is already there has its history advanced and its target refreshed. A parameter selects one of two schemes. The short scheme keeps the last two outcomes and guesses taken when either was taken. The pattern scheme keeps the last four outcomes, and these select one of sixteen 2-bit saturating counters held in the entry, so periodic sequences are learned.

A separate combinational output gives the cycle cost of a resolved branch. The cost depends on whether the guess was right and on which lane issued the branch.

Top module: `branch_hist_predictor`

## Requirements
- R1: A lookup hits only when the indexed entry (index = q_pc[7:0]) is valid and its stored tag equals q_pc[PC_W-1:8]; a different upper address on the same index misses and is replaced on its update.
- R2: In the short scheme (MODE=0) a hit predicts taken when at least one of the branch's two most recent outcomes was taken, and not taken only when both were not taken.
- R3: In the short scheme a miss predicts not taken, regardless of q_bwd.
- R4: In the pattern scheme (MODE=1) a hit predicts with the MSB of the 2-bit counter selected by the last four outcomes (newest in bit 0); on a hit update that counter steps one toward the outcome, saturating at 0 and 3. A period-3 sequence is predicted correctly after training.
- R5: In the pattern scheme a miss predicts taken when q_bwd=1 (backward target) and not taken when q_bwd=0.
- R6: An update that misses allocates the entry with the new tag and target, every history bit equal to the outcome, and (pattern scheme) every counter set to 2 for taken or 1 for not taken; an update that hits shifts the outcome into the history and overwrites the target.
- R7: p_target is the stored target on a hit and q_target on a miss.
- R8: A lookup and an update to the same entry in the same cycle return the state from before that update.
- R9: pen_cycles is 1 when c_mispred=0, 4 when c_mispred=1 and c_lane=0, and 5 when c_mispred=1 and c_lane=1.
- R10: Reset invalidates every entry, so all lookups miss afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_pc | input | PC_W | Lookup branch address |
| q_bwd | input | 1 | Static direction: 1 = target below the branch |
| q_target | input | PC_W | Decoded target used on a miss |
| u_valid | input | 1 | Resolved-branch update strobe |
| u_pc | input | PC_W | Address of the resolved branch |
| u_taken | input | 1 | Resolved outcome |
| u_target | input | PC_W | Resolved target |
| c_mispred | input | 1 | Resolved branch was mispredicted |
| c_lane | input | 1 | Issuing lane: 0 = first lane, 1 = second lane |
| p_hit | output | 1 | Lookup found the branch |
| p_taken | output | 1 | Predicted direction |
| p_target | output | PC_W | Predicted target |
| pen_cycles | output | 3 | Cost in cycles of the resolved branch |

## Verification
The hardest state to reach is a trained pattern entry whose per-history counters differ. Reaching it needs a long run of updates to one address, and each step's guess depends on every earlier step. The stimulus table drives one address through an allocation, a run of not-taken outcomes that walks the history through several counter slots, and then a period-3 sequence. The table holds the hand-derived guesses for both schemes side by side, and every table step also performs a same-cycle lookup of the entry being updated. Directed steps then force a tag conflict on the same index, an allocation as not taken and a reset in the middle of the run.

// File: rtl/branch_hist_predictor.sv
module branch_hist_predictor #(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 256,
  parameter int MODE        = 1,
  parameter int HIT_COST    = 1,
  parameter int MISS_COST_U = 4,
  parameter int MISS_COST_V = 5,
  parameter int PEN_W       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] q_pc,
  input  logic            q_bwd,
  input  logic [PC_W-1:0] q_target,
  input  logic            u_valid,
  input  logic [PC_W-1:0] u_pc,
  input  logic            u_taken,
  input  logic [PC_W-1:0] u_target,
  input  logic            c_mispred,
  input  logic            c_lane,
  output logic            p_hit,
  output logic            p_taken,
  output logic [PC_W-1:0] p_target,
  output logic [PEN_W-1:0] pen_cycles
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int TAG_W  = PC_W - IDX_W;
  localparam int HIST_W = (MODE == 0) ? 2 : 4;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [PC_W-1:0]    tgt_q  [ENTRIES];
  logic [HIST_W-1:0]  hist_q [ENTRIES];

  logic [IDX_W-1:0] q_idx, u_idx;
  logic q_hit, u_hit, dir, miss_dir;

  assign q_idx = q_pc[IDX_W-1:0];
  assign u_idx = u_pc[IDX_W-1:0];
  assign q_hit = vld[q_idx] && (tag_q[q_idx] == q_pc[PC_W-1:IDX_W]);
  assign u_hit = vld[u_idx] && (tag_q[u_idx] == u_pc[PC_W-1:IDX_W]);

  assign miss_dir   = (MODE == 1) && q_bwd;
  assign p_hit      = q_hit;
  assign p_taken    = q_hit ? dir : miss_dir;
  assign p_target   = q_hit ? tgt_q[q_idx] : q_target;
  assign pen_cycles = !c_mispred ? PEN_W'(HIT_COST)
                    : (c_lane ? PEN_W'(MISS_COST_V) : PEN_W'(MISS_COST_U));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       vld <= '0;
    else if (u_valid) vld[u_idx] <= 1'b1;

  always_ff @(posedge clk)
    if (u_valid) begin
      tag_q[u_idx]  <= u_pc[PC_W-1:IDX_W];
      tgt_q[u_idx]  <= u_target;
      hist_q[u_idx] <= u_hit ? {hist_q[u_idx][HIST_W-2:0], u_taken}
                             : {HIST_W{u_taken}};
    end

  generate
    if (MODE == 0) begin : g_short
      assign dir = |hist_q[q_idx];
    end else begin : g_pattern
      localparam int PAT = 1 << HIST_W;
      logic [2*PAT-1:0]  ctr_q [ENTRIES];
      logic [HIST_W-1:0] qh, uh;
      logic [1:0]        cur, nxt;

      assign qh  = hist_q[q_idx];
      assign uh  = hist_q[u_idx];
      assign dir = ctr_q[q_idx][{qh, 1'b1}];
      assign cur = {ctr_q[u_idx][{uh, 1'b1}], ctr_q[u_idx][{uh, 1'b0}]};

      always_comb begin
        nxt = cur;
        if (u_taken && cur != 2'b11)      nxt = cur + 2'd1;
        else if (!u_taken && cur != 2'b00) nxt = cur - 2'd1;
      end

      always_ff @(posedge clk)
        if (u_valid) begin
          if (!u_hit) ctr_q[u_idx] <= {PAT{u_taken ? 2'b10 : 2'b01}};
          else begin
            ctr_q[u_idx][{uh, 1'b1}] <= nxt[1];
            ctr_q[u_idx][{uh, 1'b0}] <= nxt[0];
          end
        end
    end
  endgenerate
endmodule

// File: rtl/bhp_checker.sv
module bhp_checker #(
  parameter int PC_W        = 32,
  parameter int MODE        = 1,
  parameter int HIT_COST    = 1,
  parameter int PEN_W       = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] q_pc,
  input logic            q_bwd,
  input logic [PC_W-1:0] q_target,
  input logic            u_valid,
  input logic [PC_W-1:0] u_pc,
  input logic            u_taken,
  input logic [PC_W-1:0] u_target,
  input logic            c_mispred,
  input logic            p_hit,
  input logic            p_taken,
  input logic [PC_W-1:0] p_target,
  input logic [PEN_W-1:0] pen_cycles
);
  p_cold_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !p_hit);

  p_short_miss_nt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0 && !p_hit) |-> !p_taken);

  p_pattern_miss_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 1 && !p_hit) |-> (p_taken == q_bwd));

  p_update_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    u_valid |=> ((q_pc != $past(u_pc)) || (p_hit && p_target == $past(u_target))));

  p_last_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0 && u_valid && u_taken) |=> ((q_pc != $past(u_pc)) || p_taken));

  p_miss_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !p_hit |-> (p_target == q_target));

  p_mispred_cost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_mispred |-> (pen_cycles > PEN_W'(HIT_COST)));
endmodule

bind branch_hist_predictor bhp_checker #(
  .PC_W(PC_W), .MODE(MODE), .HIT_COST(HIT_COST), .PEN_W(PEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .q_pc(q_pc), .q_bwd(q_bwd), .q_target(q_target),
  .u_valid(u_valid), .u_pc(u_pc), .u_taken(u_taken), .u_target(u_target),
  .c_mispred(c_mispred), .p_hit(p_hit), .p_taken(p_taken),
  .p_target(p_target), .pen_cycles(pen_cycles)
);

// File: tb/tb_branch_hist_predictor.sv
module tb_branch_hist_predictor;
  localparam int PC_W = 32;
  localparam logic [31:0] PC_A  = 32'h0000_1010;
  localparam logic [31:0] PC_B  = 32'h0000_1110;
  localparam logic [31:0] TGT_A = 32'h0000_0F00;
  localparam logic [31:0] TGT_B = 32'h0000_3000;
  // {outcome, expected hit, expected pattern-scheme guess, expected short-scheme guess}
  localparam logic [3:0] VEC [0:13] = '{
    4'b1010, 4'b0111, 4'b0111, 4'b0110, 4'b1110, 4'b0111, 4'b0111,
    4'b1110, 4'b0111, 4'b0101, 4'b1110, 4'b0101, 4'b0101, 4'b1110 };

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] q_pc = '0, q_target = '0, u_pc = '0, u_target = '0;
  logic q_bwd = 0, u_valid = 0, u_taken = 0, c_mispred = 0, c_lane = 0;
  logic p_hit, p_taken, s_hit, s_taken;
  logic [PC_W-1:0] p_target, s_target;
  logic [2:0] pen_cycles, s_pen;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  branch_hist_predictor #(.MODE(1)) dut (
    .clk(clk), .rst_n(rst_n), .q_pc(q_pc), .q_bwd(q_bwd), .q_target(q_target),
    .u_valid(u_valid), .u_pc(u_pc), .u_taken(u_taken), .u_target(u_target),
    .c_mispred(c_mispred), .c_lane(c_lane), .p_hit(p_hit), .p_taken(p_taken),
    .p_target(p_target), .pen_cycles(pen_cycles));

  branch_hist_predictor #(.MODE(0)) dut_short (
    .clk(clk), .rst_n(rst_n), .q_pc(q_pc), .q_bwd(q_bwd), .q_target(q_target),
    .u_valid(u_valid), .u_pc(u_pc), .u_taken(u_taken), .u_target(u_target),
    .c_mispred(c_mispred), .c_lane(c_lane), .p_hit(s_hit), .p_taken(s_taken),
    .p_target(s_target), .pen_cycles(s_pen));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic bwd, input logic [31:0] qt,
                       input logic uv, input logic tk, input logic [31:0] ut);
    @(negedge clk);
    q_pc = pc; q_bwd = bwd; q_target = qt;
    u_valid = uv; u_pc = pc; u_taken = tk; u_target = ut;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // reset state
    drive(PC_A, 1'b1, 32'h0000_0800, 1'b0, 1'b0, '0);
    check("R10 hit after reset", p_hit, 0);
    check("R5 backward miss", p_taken, 1);
    check("R3 short miss", s_taken, 0);
    check("R7 miss target", p_target, 32'h0000_0800);
    check("R9 correct cost", pen_cycles, 1);

    // training table; each step looks up and updates the same entry together (R8)
    for (int i = 0; i < 14; i++) begin
      drive(PC_A, 1'b1, 32'h0000_0800, 1'b1, VEC[i][3], TGT_A);
      check($sformatf("R1 R8 hit step %0d", i), p_hit, VEC[i][2]);
      check($sformatf("R4 R5 R8 pattern guess step %0d", i), p_taken, VEC[i][1]);
      check($sformatf("R2 R3 R8 short guess step %0d", i), s_taken, VEC[i][0]);
    end

    // stored target on hit
    drive(PC_A, 1'b1, 32'h0000_2000, 1'b0, 1'b0, '0);
    check("R7 stored target", p_target, TGT_A);
    check("R7 stored target short", s_target, TGT_A);

    // tag conflict on same index, forward, allocate not taken
    drive(PC_B, 1'b0, TGT_B, 1'b1, 1'b0, TGT_B);
    check("R1 tag mismatch", p_hit, 0);
    check("R5 forward miss", p_taken, 0);
    check("R3 short miss fwd", s_taken, 0);
    check("R7 miss target B", p_target, TGT_B);

    drive(PC_A, 1'b1, 32'h0000_0800, 1'b0, 1'b0, '0);
    check("R1 evicted entry misses", p_hit, 0);
    check("R1 evicted entry misses short", s_hit, 0);

    drive(PC_B, 1'b1, 32'h0000_0400, 1'b1, 1'b1, TGT_B);
    check("R6 allocated hit", p_hit, 1);
    check("R6 not-taken alloc pattern", p_taken, 0);
    check("R6 not-taken alloc short", s_taken, 0);
    check("R6 allocated target", p_target, TGT_B);

    drive(PC_B, 1'b1, 32'h0000_0400, 1'b0, 1'b0, '0);
    check("R4 new history slot counter", p_taken, 0);
    check("R2 one recent taken", s_taken, 1);

    // penalty
    @(negedge clk); c_mispred = 1; c_lane = 0; #1;
    check("R9 first lane miss", pen_cycles, 4);
    @(negedge clk); c_lane = 1; #1;
    check("R9 second lane miss", pen_cycles, 5);
    check("R9 second lane miss short", s_pen, 5);
    @(negedge clk); c_mispred = 0; #1;
    check("R9 correct on second lane", pen_cycles, 1);

    // reset clears all entries
    @(negedge clk) rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    drive(PC_B, 1'b1, 32'h0000_0400, 1'b0, 1'b0, '0);
    check("R10 cleared entry", p_hit, 0);
    check("R10 cleared entry short", s_hit, 0);
    check("R5 backward after reset", p_taken, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule